// File: doc/BRIEF.md
# Conversion Result Holding Register with Overrun Policy

This block sits between a sequenced multi-channel converter front end and the system bus. Each time the front end finishes a conversion it pulses a done strobe together with the result, the channel index and a last-in-sequence marker. The block keeps the most recent result and its channel in one shared data register. A bus reader or a DMA engine empties that register. The block raises three status flags: result ready, sequence finished and overrun. Each flag can be routed to a single interrupt line.

All channels share one data register. A result that has not been collected when the next conversion finishes is an overrun. A configuration bit selects how an overrun is handled. In the strict policy the unread value is kept, the overrun flag is raised and a halt request is sent to the sequencer. The halt request holds until software acknowledges the overrun. In the relaxed policy the newest result always replaces the old one, the overrun flag is still raised, and conversion is never halted. When DMA is enabled, every converted channel raises its own transfer request.

Top module: `adc_result_hold`

## Requirements
- R1: After reset the data and channel outputs are 0, and all flags, the halt request, the DMA request and the interrupt are 0.
- R2: A done strobe that is accepted without an overrun loads the result and the channel into the outputs on the next cycle and sets the ready flag (flags bit 0).
- R3: An accepted and loaded conversion that carries the last-in-sequence marker sets the sequence-finished flag (flags bit 1).
- R4: A data read strobe clears the ready flag on the next cycle. When a read and a done strobe occur in the same cycle, the read counts first: no overrun is raised, the new result is loaded and the ready flag stays set.
- R5: With the overwrite bit at 0, a done strobe that arrives while the ready flag is set and no read or acknowledge occurs in that cycle keeps the old data. It sets the overrun flag (flags bit 2) and the halt request. It raises neither the sequence-finished flag nor a DMA request.
- R6: The halt request stays high until software writes 1 to the overrun bit. Done strobes that arrive while the halt request is high change neither the data nor any flag.
- R7: With the overwrite bit at 1, an overrun loads the newest result and sets the overrun flag. The halt request stays at 0.
- R8: With DMA enabled, every loaded conversion sets the DMA request. A DMA acknowledge clears both the DMA request and the ready flag. With DMA disabled, no request is raised.
- R9: A status write clears every flag whose bit is 1 in the write data (bit 0 ready, bit 1 sequence finished, bit 2 overrun). Bits written as 0 leave their flags unchanged. In the same cycle a flag being set takes priority over its clear.
- R10: The interrupt output is high whenever any flag is high while its enable bit, at the same bit position, is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | DATA_W | Conversion result |
| conv_chan_i | input | CH_W | Channel index of the result |
| conv_last_i | input | 1 | Result is the last channel of the sequence |
| cfg_overwrite_i | input | 1 | Overrun policy: 0 keeps old data and halts, 1 overwrites |
| cfg_dma_en_i | input | 1 | Enable a DMA request for each conversion |
| cfg_irq_en_i | input | 3 | Interrupt enables, same bit order as flags |
| rd_data_i | input | 1 | Bus read of the data register |
| dma_ack_i | input | 1 | DMA transfer acknowledge |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 3 | Write-1-to-clear mask for the flags |
| data_o | output | DATA_W | Held result |
| chan_o | output | CH_W | Channel of the held result |
| flags_o | output | 3 | {overrun, sequence finished, ready} |
| halt_o | output | 1 | Halt request to the sequencer |
| dma_req_o | output | 1 | DMA transfer request |
| irq_o | output | 1 | Interrupt |

## Verification
The in-line assertions check on every cycle the properties that hold over a single step. An unread result followed by a done strobe must raise the overrun flag. The halt request must never appear without the overrun flag, and it must persist until the overrun is cleared. The data must stay frozen while the block is halted. The relaxed policy must never halt, a read must drop the ready flag, and a loaded conversion must raise a DMA request when DMA is enabled. Other behaviours need the bench's scenarios. These include the read-before-strobe ordering within one cycle, the priority of a set over a clear, zero bits in a status write being ignored, the interrupt masking across mode and enable changes, and long random mixes of both policies against a cycle model.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
    localparam int FLAG_N  = 3;
    localparam int FL_RDY  = 0;
    localparam int FL_SEQ  = 1;
    localparam int FL_OVR  = 2;

    typedef struct packed {
        logic              halt;
        logic              dreq;
        logic [FLAG_N-1:0] flags;
    } stat_t;
endpackage

// File: rtl/adc_res_capture.sv
module adc_res_capture #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CH_W-1:0]   chan_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CH_W-1:0]   chan_o
);
    localparam int HOLD_W = DATA_W + CH_W;

    logic [HOLD_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d = {chan_i, data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data_o = hold_q[DATA_W-1:0];
    assign chan_o = hold_q[HOLD_W-1:DATA_W];
endmodule

// File: rtl/adc_res_status.sv
module adc_res_status
    import adc_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done_i,
    input  logic              conv_last_i,
    input  logic              cfg_overwrite_i,
    input  logic              cfg_dma_en_i,
    input  logic              rd_data_i,
    input  logic              dma_ack_i,
    input  logic              sts_wr_i,
    input  logic [FLAG_N-1:0] sts_wdata_i,
    output logic              load_o,
    output logic [FLAG_N-1:0] flags_o,
    output logic              halt_o,
    output logic              dma_req_o
);
    stat_t st_d, st_q;
    logic  accept, taken, busy, ovr_ev, load;

    always_comb begin
        st_d   = st_q;
        accept = conv_done_i && !st_q.halt;
        taken  = rd_data_i || dma_ack_i;
        busy   = st_q.flags[FL_RDY] && !taken;
        ovr_ev = accept && busy;
        load   = accept && (!busy || cfg_overwrite_i);

        // clears first
        if (taken) begin
            st_d.flags[FL_RDY] = 1'b0;
        end
        if (dma_ack_i) begin
            st_d.dreq = 1'b0;
        end
        if (sts_wr_i) begin
            st_d.flags = st_d.flags & ~sts_wdata_i;
            if (sts_wdata_i[FL_OVR]) begin
                st_d.halt = 1'b0;
            end
        end

        // sets take priority
        if (load) begin
            st_d.flags[FL_RDY] = 1'b1;
            if (conv_last_i) begin
                st_d.flags[FL_SEQ] = 1'b1;
            end
            if (cfg_dma_en_i) begin
                st_d.dreq = 1'b1;
            end
        end
        if (ovr_ev) begin
            st_d.flags[FL_OVR] = 1'b1;
            if (!cfg_overwrite_i) begin
                st_d.halt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o    = load;
    assign flags_o   = st_q.flags;
    assign halt_o    = st_q.halt;
    assign dma_req_o = st_q.dreq;

    p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && !halt_o && flags_o[FL_RDY] && !rd_data_i && !dma_ack_i)
        |=> flags_o[FL_OVR]);

    p_halt_has_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> flags_o[FL_OVR]);

    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !(sts_wr_i && sts_wdata_i[FL_OVR])) |=> halt_o);

    p_never_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_overwrite_i && !halt_o) |=> !halt_o);

    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !conv_done_i) |=> !flags_o[FL_RDY]);

    p_dma_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && cfg_dma_en_i) |=> dma_req_o);
endmodule

// File: rtl/adc_res_irq.sv
module adc_res_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic [N-1:0] masked;

    for (genvar g = 0; g < N; g++) begin : g_mask
        assign masked[g] = flags_i[g] & en_i[g];
    end

    assign irq_o = |masked;
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
    import adc_res_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    input  logic [CH_W-1:0]   conv_chan_i,
    input  logic              conv_last_i,
    input  logic              cfg_overwrite_i,
    input  logic              cfg_dma_en_i,
    input  logic [2:0]        cfg_irq_en_i,
    input  logic              rd_data_i,
    input  logic              dma_ack_i,
    input  logic              sts_wr_i,
    input  logic [2:0]        sts_wdata_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CH_W-1:0]   chan_o,
    output logic [2:0]        flags_o,
    output logic              halt_o,
    output logic              dma_req_o,
    output logic              irq_o
);
    logic load;

    adc_res_status i_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_done_i    (conv_done_i),
        .conv_last_i    (conv_last_i),
        .cfg_overwrite_i(cfg_overwrite_i),
        .cfg_dma_en_i   (cfg_dma_en_i),
        .rd_data_i      (rd_data_i),
        .dma_ack_i      (dma_ack_i),
        .sts_wr_i       (sts_wr_i),
        .sts_wdata_i    (sts_wdata_i),
        .load_o         (load),
        .flags_o        (flags_o),
        .halt_o         (halt_o),
        .dma_req_o      (dma_req_o)
    );

    adc_res_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) i_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .data_i(conv_data_i),
        .chan_i(conv_chan_i),
        .data_o(data_o),
        .chan_o(chan_o)
    );

    adc_res_irq #(.N(FLAG_N)) i_irq (
        .flags_i(flags_o),
        .en_i   (cfg_irq_en_i),
        .irq_o  (irq_o)
    );

    p_halted_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && halt_o) |=> ($stable(data_o) && $stable(chan_o)));

    p_keep_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && !cfg_overwrite_i && flags_o[FL_RDY] && !rd_data_i && !dma_ack_i)
        |=> $stable(data_o));
endmodule

// File: tb/test_adc_result_hold.sv
module test_adc_result_hold;
    localparam int DW = 12;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_done_i = 1'b0;
    logic [DW-1:0] conv_data_i = '0;
    logic [CW-1:0] conv_chan_i = '0;
    logic          conv_last_i = 1'b0;
    logic          cfg_overwrite_i = 1'b0;
    logic          cfg_dma_en_i = 1'b0;
    logic [2:0]    cfg_irq_en_i = '0;
    logic          rd_data_i = 1'b0;
    logic          dma_ack_i = 1'b0;
    logic          sts_wr_i = 1'b0;
    logic [2:0]    sts_wdata_i = '0;
    logic [DW-1:0] data_o;
    logic [CW-1:0] chan_o;
    logic [2:0]    flags_o;
    logic          halt_o, dma_req_o, irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // expected state
    logic [DW-1:0] m_data = '0;
    logic [CW-1:0] m_chan = '0;
    logic [2:0]    m_flags = '0;
    logic          m_halt = 1'b0;
    logic          m_dreq = 1'b0;

    always #2 clk = ~clk;

    adc_result_hold #(.DATA_W(DW), .CH_W(CW)) i_adc_result_hold (
        .clk(clk), .rst_n(rst_n),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .conv_chan_i(conv_chan_i), .conv_last_i(conv_last_i),
        .cfg_overwrite_i(cfg_overwrite_i), .cfg_dma_en_i(cfg_dma_en_i),
        .cfg_irq_en_i(cfg_irq_en_i), .rd_data_i(rd_data_i),
        .dma_ack_i(dma_ack_i), .sts_wr_i(sts_wr_i), .sts_wdata_i(sts_wdata_i),
        .data_o(data_o), .chan_o(chan_o), .flags_o(flags_o),
        .halt_o(halt_o), .dma_req_o(dma_req_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq(logic [2:0] f, logic [2:0] en);
        return |(f & en);
    endfunction

    task automatic compare_all();
        check("R2 data", 32'(data_o), 32'(m_data));
        check("R2 chan", 32'(chan_o), 32'(m_chan));
        check("R4 ready flag", 32'(flags_o[0]), 32'(m_flags[0]));
        check("R3 seq flag", 32'(flags_o[1]), 32'(m_flags[1]));
        check("R5 ovr flag", 32'(flags_o[2]), 32'(m_flags[2]));
        check("R6 halt", 32'(halt_o), 32'(m_halt));
        check("R8 dma req", 32'(dma_req_o), 32'(m_dreq));
        check("R10 irq", 32'(irq_o), 32'(exp_irq(m_flags, cfg_irq_en_i)));
    endtask

    // one cycle: drive at negedge, update model, check after posedge
    task automatic step(logic done, logic [DW-1:0] d, logic [CW-1:0] ch, logic last,
                        logic rd, logic ack, logic wr, logic [2:0] wd);
        logic acc, took, busy, oev, ld;
        @(negedge clk);
        conv_done_i = done; conv_data_i = d; conv_chan_i = ch; conv_last_i = last;
        rd_data_i = rd; dma_ack_i = ack; sts_wr_i = wr; sts_wdata_i = wd;
        acc  = done && !m_halt;
        took = rd || ack;
        busy = m_flags[0] && !took;
        oev  = acc && busy;
        ld   = acc && (!busy || cfg_overwrite_i);
        if (took) m_flags[0] = 1'b0;
        if (ack) m_dreq = 1'b0;
        if (wr) begin
            m_flags = m_flags & ~wd;
            if (wd[2]) m_halt = 1'b0;
        end
        if (ld) begin
            m_data = d; m_chan = ch; m_flags[0] = 1'b1;
            if (last) m_flags[1] = 1'b1;
            if (cfg_dma_en_i) m_dreq = 1'b1;
        end
        if (oev) begin
            m_flags[2] = 1'b1;
            if (!cfg_overwrite_i) m_halt = 1'b1;
        end
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        step(0, '0, '0, 0, 0, 0, 0, 3'b000);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        cfg_irq_en_i = 3'b111;
        #9;
        // R1 reset state
        check("R1 data", 32'(data_o), 0);
        check("R1 flags", 32'(flags_o), 0);
        check("R1 halt", 32'(halt_o), 0);
        check("R1 dma", 32'(dma_req_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2, R3 basic load with last marker
        step(1, 12'h1A5, 5'd3, 1, 0, 0, 0, 3'b000);
        check("R2 loaded", 32'(data_o), 32'h1A5);
        check("R3 seq set", 32'(flags_o[1]), 1);
        // R4 read and strobe same cycle: no overrun
        step(1, 12'h2B6, 5'd4, 0, 1, 0, 0, 3'b000);
        check("R4 no ovr", 32'(flags_o[2]), 0);
        check("R4 new data", 32'(data_o), 32'h2B6);
        step(0, '0, '0, 0, 1, 0, 0, 3'b000);
        check("R4 read clears", 32'(flags_o[0]), 0);
        // R9 writing zeros has no effect
        step(0, '0, '0, 0, 0, 0, 1, 3'b000);
        check("R9 zero write keeps seq", 32'(flags_o[1]), 1);
        step(0, '0, '0, 0, 0, 0, 1, 3'b010);
        check("R9 w1c seq", 32'(flags_o[1]), 0);

        // R5 strict overrun
        step(1, 12'h111, 5'd1, 0, 0, 0, 0, 3'b000);
        step(1, 12'h222, 5'd2, 1, 0, 0, 0, 3'b000);
        check("R5 keep old", 32'(data_o), 32'h111);
        check("R5 halt", 32'(halt_o), 1);
        check("R5 no seq", 32'(flags_o[1]), 0);
        // R6 ignored while halted
        step(0, '0, '0, 0, 1, 0, 0, 3'b000);
        step(1, 12'h333, 5'd3, 1, 0, 0, 0, 3'b000);
        check("R6 ignored data", 32'(data_o), 32'h111);
        check("R6 ignored ready", 32'(flags_o[0]), 0);
        step(0, '0, '0, 0, 0, 0, 1, 3'b011);
        check("R6 still halted", 32'(halt_o), 1);
        step(0, '0, '0, 0, 0, 0, 1, 3'b100);
        check("R6 released", 32'(halt_o), 0);

        // R7 relaxed overrun
        cfg_overwrite_i = 1'b1;
        step(1, 12'h444, 5'd4, 0, 0, 0, 0, 3'b000);
        step(1, 12'h555, 5'd5, 0, 0, 0, 0, 3'b000);
        check("R7 newest", 32'(data_o), 32'h555);
        check("R7 ovr", 32'(flags_o[2]), 1);
        check("R7 no halt", 32'(halt_o), 0);
        step(0, '0, '0, 0, 1, 0, 1, 3'b111);

        // R8 dma per conversion
        cfg_dma_en_i = 1'b1;
        step(1, 12'h666, 5'd6, 0, 0, 0, 0, 3'b000);
        check("R8 req", 32'(dma_req_o), 1);
        step(0, '0, '0, 0, 0, 1, 0, 3'b000);
        check("R8 ack clears req", 32'(dma_req_o), 0);
        check("R8 ack clears ready", 32'(flags_o[0]), 0);

        // R10 masking
        cfg_irq_en_i = 3'b000;
        step(1, 12'h777, 5'd7, 0, 0, 0, 0, 3'b000);
        check("R10 masked", 32'(irq_o), 0);
        step(0, '0, '0, 0, 0, 1, 0, 3'b000);

        // random mix
        for (int blk = 0; blk < 16; blk++) begin
            cfg_overwrite_i = 1'($urandom_range(0, 1));
            cfg_dma_en_i    = 1'($urandom_range(0, 1));
            cfg_irq_en_i    = 3'($urandom_range(0, 7));
            for (int k = 0; k < 200; k++) begin
                step($urandom_range(0, 9) < 4, DW'($urandom), CW'($urandom),
                     $urandom_range(0, 3) == 0, $urandom_range(0, 9) < 3,
                     m_dreq && ($urandom_range(0, 9) < 4),
                     $urandom_range(0, 9) == 0, 3'($urandom_range(0, 7)));
            end
        end
        idle();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule